// File: doc/BRIEF.md
# Dual-Role Cell Input Port

This block receives fixed-size ATM cells from a cell-level parallel bus and writes them, one transfer at a time, into a cell buffer. A static role input selects which end of the bus it plays. As the ATM-side master it watches the far end's cell-available line and drives an active-low enable for exactly one cell's worth of cycles. As the PHY-side slave it answers address polls with a registered cell-available and takes data while the master holds its active-low enable low.

A static width input selects byte transfers (53 per cell) or 16-bit transfers (27 per cell, the header followed by one pad byte). Every transfer is checked for odd parity over the active lanes. Start-of-cell is checked for alignment: a start-of-cell inside a cell drops the partial cell and restarts. A buffer-room input from the consumer gates any new cell. The buffer sees a write strobe with index and data, and a cell-done strobe that carries the cell's parity error flag and error count. The bus clock comes from outside the block, either a divided master clock or an external source.

Top module: `utopia_cell_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, `hs_out` is 1 in ATM-side role (`role_phy`=0), meaning the enable is deasserted, and 0 in PHY-side role (`role_phy`=1). `wr_en`, `cell_done` and `runt_err` are 0.
- R2: ATM-side role: when `hs_in` (far end has a cell) and `buf_room` are both 1 at a clock edge while no burst is running, `hs_out` goes low after that edge. It stays low for exactly one cell length of cycles and then returns high. With `buf_room`=0 it stays high.
- R3: ATM-side role: the bus is sampled at the end of the cycle that follows each cycle of enable low, so the n-th written transfer of the cell is the bus value in the cycle after the n-th low cycle.
- R4: PHY-side role: `hs_out` (cell available) is 1 in a cycle only if, at the previous edge, `bus_addr` equalled the parameter `DEV_ADDR`, `buf_room` was 1 and no cell was in progress.
- R5: PHY-side role: transfers are accepted only at edges where `hs_in` is 0 and the device was selected. Selection means `bus_addr` equalled `DEV_ADDR` at the last edge where `hs_in` was 1. A burst to another address writes nothing.
- R6: Byte mode (`wide`=0): a cell is 53 transfers, `wr_idx` runs 0..52, and `bus_data[15:8]` is ignored: `wr_data[15:8]` is 0 and those bits do not enter parity.
- R7: 16-bit mode (`wide`=1): a cell is 27 transfers, `wr_idx` runs 0..26, `wr_data` carries all 16 bits, and `cell_done` pulses with the write of index 26.
- R8: Parity is odd: a transfer is in error when the XOR of `bus_par` and the active data bits (all 16, or [7:0] in byte mode) is 0. A cell with errors is still written in full. At `cell_done`, `cell_err` is 1 if any transfer erred, and `par_err_cnt` gives the number of erred transfers. `par_err_cnt` holds until the next `cell_done`.
- R9: A transfer with `bus_soc`=1 received while a cell is in progress pulses `runt_err`, discards the partial cell and starts a new cell with that transfer written at index 0.
- R10: Accepted transfers with `bus_soc`=0 while no cell is in progress are discarded without a write.
- R11: In ATM-side role `bus_addr` has no effect.
- R12: The write strobe for a transfer appears in the cycle after the edge that samples it, one register stage later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| role_phy | input | 1 | 0: ATM-side master, 1: PHY-side slave (static) |
| wide | input | 1 | 0: byte transfers, 1: 16-bit transfers (static) |
| buf_room | input | 1 | Buffer can take one whole cell |
| bus_addr | input | 5 | Poll/select address (PHY-side role only) |
| bus_data | input | 16 | Bus data |
| bus_par | input | 1 | Odd parity over the active data lanes |
| bus_soc | input | 1 | Start of cell, active high |
| hs_in | input | 1 | ATM-side: far-end cell available; PHY-side: active-low enable |
| hs_out | output | 1 | ATM-side: active-low enable; PHY-side: cell available |
| wr_en | output | 1 | Buffer write strobe |
| wr_idx | output | 6 | Transfer index within the cell |
| wr_data | output | 16 | Transfer data (upper byte 0 in byte mode) |
| cell_done | output | 1 | Last transfer of a cell written |
| cell_err | output | 1 | Finished cell had a parity error (valid with cell_done) |
| runt_err | output | 1 | Partial cell dropped on early start-of-cell |
| par_err_cnt | output | 6 | Parity errors in the last finished cell |

## Verification
The write strobe and cell-done for a transfer are due two edges after the cycle in which the bench drives it: the first edge loads the input stage and the second loads the outputs. The bench reads these results at the falling edge after that second edge, and in one directed case it confirms that `cell_done` is still low one falling edge earlier. The ATM-side enable is due at the first falling edge after the edge that sees cell-available. The bench then counts low samples over the burst, driving each transfer one cycle behind the matching low cycle. A PHY-side poll answer is read two falling edges after the address is driven, which allows for its single register.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;

    localparam int BUS_W      = 16;
    localparam int HALF_W     = 8;
    localparam int ADDR_W     = 5;
    localparam int BYTE_CELL  = 53;
    localparam int WORD_CELL  = 27;
    localparam int IDX_W      = $clog2(BYTE_CELL + 1);

    typedef enum logic {
        ROLE_ATM = 1'b0,
        ROLE_PHY = 1'b1
    } role_e;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             soc;
        logic             par;
    } xfer_t;

    function automatic logic [IDX_W-1:0] cell_len(input logic wide);
        return wide ? IDX_W'(WORD_CELL) : IDX_W'(BYTE_CELL);
    endfunction

    function automatic logic par_ok(input logic [BUS_W-1:0] d, input logic p,
                                    input logic wide);
        return wide ? (^{d, p}) : (^{d[HALF_W-1:0], p});
    endfunction

    function automatic logic [BUS_W-1:0] lane_mask(input logic [BUS_W-1:0] d,
                                                   input logic wide);
        return wide ? d : {{(BUS_W-HALF_W){1'b0}}, d[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/utopia_rx_master.sv
module utopia_rx_master
    import utopia_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act,
    input  logic wide,
    input  logic far_clav,
    input  logic buf_room,
    output logic enb_n,
    output logic take
);
    logic             enb_q;
    logic             smp_q;
    logic [IDX_W-1:0] left_q;

    // Enable burst of exactly one cell length; sampling lags one cycle.
    always_ff @(posedge clk) begin
        if (rst || !act) begin
            enb_q  <= 1'b0;
            smp_q  <= 1'b0;
            left_q <= '0;
        end else begin
            smp_q <= enb_q;
            if (enb_q) begin
                if (left_q == '0) begin
                    enb_q <= 1'b0;
                end else begin
                    left_q <= left_q - IDX_W'(1);
                end
            end else if (far_clav && buf_room) begin
                enb_q  <= 1'b1;
                left_q <= cell_len(wide) - IDX_W'(1);
            end
        end
    end

    assign enb_n = ~enb_q;
    assign take  = act && smp_q;

endmodule

// File: rtl/utopia_rx_slave.sv
module utopia_rx_slave
    import utopia_rx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 5'd9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic [ADDR_W-1:0] addr,
    input  logic              enb_n,
    input  logic              buf_room,
    input  logic              in_cell,
    output logic              clav,
    output logic              take
);
    logic sel_q;
    logic clav_q;
    logic hit;

    assign hit = (addr == DEV_ADDR);

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            sel_q  <= 1'b0;
            clav_q <= 1'b0;
        end else begin
            // Selection latches on the last cycle with enable idle.
            if (enb_n) begin
                sel_q <= hit;
            end
            clav_q <= hit && buf_room && !in_cell;
        end
    end

    assign clav = clav_q;
    assign take = act && !enb_n && sel_q;

endmodule

// File: rtl/utopia_rx_cell.sv
module utopia_rx_cell
    import utopia_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wide,
    input  logic             take,
    input  logic [BUS_W-1:0] bus_data,
    input  logic             bus_soc,
    input  logic             bus_par,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [BUS_W-1:0] wr_data,
    output logic             cell_done,
    output logic             cell_err,
    output logic             runt_err,
    output logic [IDX_W-1:0] par_err_cnt,
    output logic             in_cell
);
    xfer_t            stg_q;
    logic             stg_v_q;
    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] run_cnt_q;
    logic             bad;
    logic [IDX_W-1:0] cnt_now;
    logic             last;

    // Input stage: one register between the bus and the assembler.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_v_q <= 1'b0;
            stg_q   <= '0;
        end else begin
            stg_v_q <= take;
            if (take) begin
                stg_q <= '{data: bus_data, soc: bus_soc, par: bus_par};
            end
        end
    end

    assign bad     = !par_ok(stg_q.data, stg_q.par, wide);
    assign cnt_now = run_cnt_q + IDX_W'(bad);
    assign last    = (idx_q == cell_len(wide) - IDX_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q    <= 1'b0;
            idx_q       <= '0;
            run_cnt_q   <= '0;
            wr_en       <= 1'b0;
            wr_idx      <= '0;
            wr_data     <= '0;
            cell_done   <= 1'b0;
            cell_err    <= 1'b0;
            runt_err    <= 1'b0;
            par_err_cnt <= '0;
        end else begin
            wr_en     <= 1'b0;
            cell_done <= 1'b0;
            runt_err  <= 1'b0;
            if (stg_v_q) begin
                wr_data <= lane_mask(stg_q.data, wide);
                if (stg_q.soc) begin
                    runt_err  <= active_q;
                    wr_en     <= 1'b1;
                    wr_idx    <= '0;
                    idx_q     <= IDX_W'(1);
                    active_q  <= 1'b1;
                    run_cnt_q <= IDX_W'(bad);
                end else if (active_q) begin
                    wr_en  <= 1'b1;
                    wr_idx <= idx_q;
                    if (last) begin
                        cell_done   <= 1'b1;
                        cell_err    <= (cnt_now != '0);
                        par_err_cnt <= cnt_now;
                        active_q    <= 1'b0;
                        idx_q       <= '0;
                        run_cnt_q   <= '0;
                    end else begin
                        idx_q     <= idx_q + IDX_W'(1);
                        run_cnt_q <= cnt_now;
                    end
                end
            end
        end
    end

    assign in_cell = active_q || stg_v_q;

endmodule

// File: rtl/utopia_cell_rx.sv
module utopia_cell_rx
    import utopia_rx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 5'd9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              role_phy,
    input  logic              wide,
    input  logic              buf_room,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_data,
    input  logic              bus_par,
    input  logic              bus_soc,
    input  logic              hs_in,
    output logic              hs_out,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BUS_W-1:0]  wr_data,
    output logic              cell_done,
    output logic              cell_err,
    output logic              runt_err,
    output logic [IDX_W-1:0]  par_err_cnt
);
    role_e role;
    logic  m_enb_n, m_take;
    logic  s_clav, s_take;
    logic  in_cell;
    logic  take;

    assign role = role_e'(role_phy);

    utopia_rx_master u_master (
        .clk      (clk),
        .rst      (rst),
        .act      (role == ROLE_ATM),
        .wide     (wide),
        .far_clav (hs_in),
        .buf_room (buf_room),
        .enb_n    (m_enb_n),
        .take     (m_take)
    );

    utopia_rx_slave #(.DEV_ADDR(DEV_ADDR)) u_slave (
        .clk      (clk),
        .rst      (rst),
        .act      (role == ROLE_PHY),
        .addr     (bus_addr),
        .enb_n    (hs_in),
        .buf_room (buf_room),
        .in_cell  (in_cell),
        .clav     (s_clav),
        .take     (s_take)
    );

    assign take   = (role == ROLE_PHY) ? s_take : m_take;
    assign hs_out = (role == ROLE_PHY) ? s_clav : m_enb_n;

    utopia_rx_cell u_cell (
        .clk         (clk),
        .rst         (rst),
        .wide        (wide),
        .take        (take),
        .bus_data    (bus_data),
        .bus_soc     (bus_soc),
        .bus_par     (bus_par),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .cell_done   (cell_done),
        .cell_err    (cell_err),
        .runt_err    (runt_err),
        .par_err_cnt (par_err_cnt),
        .in_cell     (in_cell)
    );

endmodule

// File: rtl/utopia_cell_rx_chk.sv
module utopia_cell_rx_chk
    import utopia_rx_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEV_ADDR = 5'd9
) (
    input logic              clk,
    input logic              rst,
    input logic              role_phy,
    input logic              wide,
    input logic              buf_room,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              hs_out,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [BUS_W-1:0]  wr_data,
    input logic              cell_done,
    input logic              cell_err,
    input logic              runt_err,
    input logic [IDX_W-1:0]  par_err_cnt
);
    logic [IDX_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run <= '0;
        end else if (!role_phy && !hs_out) begin
            low_run <= low_run + IDX_W'(1);
        end else begin
            low_run <= '0;
        end
    end

    assert_enb_burst_R2: assert property (@(posedge clk) disable iff (rst)
        (!role_phy && !hs_out) |-> (low_run < cell_len(wide)));

    assert_clav_poll_R4: assert property (@(posedge clk) disable iff (rst)
        (role_phy && hs_out) |-> ($past(bus_addr) == DEV_ADDR && $past(buf_room)));

    assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx < cell_len(wide)));

    assert_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wide) |-> (wr_data[BUS_W-1:HALF_W] == '0));

    assert_done_last_R7: assert property (@(posedge clk) disable iff (rst)
        cell_done |-> (wr_en && wr_idx == cell_len(wide) - IDX_W'(1)));

    assert_err_count_R8: assert property (@(posedge clk) disable iff (rst)
        cell_done |-> (cell_err == (par_err_cnt != '0)));

    assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!cell_done && !$past(rst)) |-> $stable(par_err_cnt));

    assert_runt_restart_R9: assert property (@(posedge clk) disable iff (rst)
        runt_err |-> (wr_en && wr_idx == '0));

endmodule

bind utopia_cell_rx utopia_cell_rx_chk #(.DEV_ADDR(DEV_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .role_phy    (role_phy),
    .wide        (wide),
    .buf_room    (buf_room),
    .bus_addr    (bus_addr),
    .hs_out      (hs_out),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .cell_done   (cell_done),
    .cell_err    (cell_err),
    .runt_err    (runt_err),
    .par_err_cnt (par_err_cnt)
);

// File: tb/utopia_cell_rx_tb.sv
`timescale 1ns/1ps
module utopia_cell_rx_tb;

    localparam logic [4:0] DEV = 5'd9;

    logic        clk = 1'b0;
    logic        rst;
    logic        role_phy, wide, buf_room, bus_par, bus_soc, hs_in;
    logic [4:0]  bus_addr;
    logic [15:0] bus_data;
    logic        hs_out, wr_en, cell_done, cell_err, runt_err;
    logic [5:0]  wr_idx, par_err_cnt;
    logic [15:0] wr_data;

    int nchecks = 0;
    int nerr    = 0;
    int nwr = 0, ndone = 0, nrunt = 0;
    int last_cnt = 0;
    logic last_err = 1'b0;
    logic [15:0] raw [0:52];
    logic        bad [0:52];
    logic [15:0] cap [0:52];

    always #4 clk = ~clk;

    utopia_cell_rx #(.DEV_ADDR(DEV)) u_dut (
        .clk(clk), .rst(rst), .role_phy(role_phy), .wide(wide),
        .buf_room(buf_room), .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_par(bus_par), .bus_soc(bus_soc), .hs_in(hs_in),
        .hs_out(hs_out), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .cell_done(cell_done), .cell_err(cell_err), .runt_err(runt_err),
        .par_err_cnt(par_err_cnt)
    );

    // Output monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_en) begin
                nwr++;
                cap[wr_idx] = wr_data;
            end
            if (cell_done) begin
                ndone++;
                last_err = cell_err;
                last_cnt = int'(par_err_cnt);
            end
            if (runt_err) nrunt++;
        end
    end

    function automatic int len_of(input logic w);
        return w ? 27 : 53;
    endfunction

    function automatic logic [15:0] exp_word(input logic [15:0] d, input logic w);
        return w ? d : {8'h00, d[7:0]};
    endfunction

    function automatic logic odd_bit(input logic [15:0] d, input logic w);
        return w ? ~(^d) : ~(^d[7:0]);
    endfunction

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic gen_cell(input int nbad);
        for (int i = 0; i < 53; i++) begin
            raw[i] = 16'($urandom);
            bad[i] = 1'b0;
        end
        for (int k = 0; k < nbad; k++) bad[k * 5 + 2] = 1'b1;
    endtask

    task automatic drive_word(input int i);
        bus_data = raw[i];
        bus_soc  = (i == 0);
        bus_par  = odd_bit(raw[i], wide) ^ bad[i];
    endtask

    function automatic int mismatches(input logic w);
        int m = 0;
        for (int i = 0; i < len_of(w); i++)
            if (cap[i] !== exp_word(raw[i], w)) m++;
        return m;
    endfunction

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic apply_reset(input logic phy, input logic w);
        @(negedge clk);
        rst = 1'b1; role_phy = phy; wide = w;
        hs_in = phy; bus_soc = 1'b0; bus_data = '0; bus_par = 1'b0;
        bus_addr = 5'd0; buf_room = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1", "hs_out in reset", int'(hs_out), phy ? 0 : 1);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "hs_out after reset", int'(hs_out), phy ? 0 : 1);
        check_eq("R1", "wr_en after reset", int'(wr_en), 0);
        check_eq("R1", "cell_done after reset", int'(cell_done | runt_err), 0);
    endtask

    task automatic phy_poll(input logic [4:0] a, input logic exp_clav, input string req);
        @(negedge clk);
        bus_addr = a; hs_in = 1'b1; bus_soc = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_eq(req, "clav poll answer", int'(hs_out), int'(exp_clav));
    endtask

    task automatic phy_burst(input int n, input int first, input bit lat);
        for (int i = first; i < first + n; i++) begin
            @(negedge clk);
            hs_in = 1'b0;
            drive_word(i);
            bus_addr = 5'($urandom);
        end
        @(negedge clk);
        hs_in = 1'b1; bus_soc = 1'b0;
        if (lat) check_eq("R12", "cell_done one edge after accept", int'(cell_done), 0);
        @(negedge clk);
        if (lat) check_eq("R12", "cell_done two edges after drive", int'(cell_done), 1);
    endtask

    task automatic phy_cell(input int nbad, input string req);
        int d0, w0;
        gen_cell(nbad);
        d0 = ndone; w0 = nwr;
        phy_poll(DEV, 1'b1, "R4");
        phy_burst(len_of(wide), 0, 1'b0);
        settle();
        check_eq(req, "writes per cell", nwr - w0, len_of(wide));
        check_eq(req, "cells done", ndone - d0, 1);
        check_eq(req, "data mismatches", mismatches(wide), 0);
        check_eq("R8", "parity error count", last_cnt, nbad);
        check_eq("R8", "cell error flag", int'(last_err), nbad != 0 ? 1 : 0);
    endtask

    task automatic atm_cell(input int nbad);
        int low, d0, w0;
        gen_cell(nbad);
        d0 = ndone; w0 = nwr;
        @(negedge clk);
        hs_in = 1'b1; bus_addr = 5'($urandom);
        @(negedge clk);
        check_eq("R2", "enable one cycle after cell-available", int'(hs_out), 0);
        hs_in = 1'b0;
        low = 1;
        for (int i = 0; i < len_of(wide); i++) begin
            @(negedge clk);
            if (hs_out == 1'b0) low++;
            drive_word(i);
            bus_addr = 5'($urandom);  // R11: ignored in this role
        end
        check_eq("R2", "enable low cycles", low, len_of(wide));
        @(negedge clk);
        bus_soc = 1'b0;
        check_eq("R2", "enable released", int'(hs_out), 1);
        settle();
        check_eq("R3", "writes per cell", nwr - w0, len_of(wide));
        check_eq("R3", "cells done", ndone - d0, 1);
        check_eq("R11", "data with random address", mismatches(wide), 0);
        check_eq("R8", "parity error count", last_cnt, nbad);
    endtask

    initial begin
        int w0, d0, r0, lows;
        void'($urandom(32'd20240611));
        rst = 1'b1; role_phy = 1'b0; wide = 1'b0; buf_room = 1'b1;
        hs_in = 1'b0; bus_addr = '0; bus_data = '0; bus_par = 1'b0; bus_soc = 1'b0;

        // ATM-side role, byte mode
        apply_reset(1'b0, 1'b0);
        atm_cell(0);
        atm_cell(2);
        // R2: no room, enable stays high
        @(negedge clk);
        buf_room = 1'b0; hs_in = 1'b1;
        lows = 0;
        repeat (5) begin
            @(negedge clk);
            if (hs_out == 1'b0) lows++;
        end
        check_eq("R2", "no enable without room", lows, 0);
        hs_in = 1'b0; buf_room = 1'b1;
        repeat (4) @(negedge clk);

        // ATM-side role, 16-bit mode
        apply_reset(1'b0, 1'b1);
        atm_cell(1);
        atm_cell(0);

        // PHY-side role, byte mode
        apply_reset(1'b1, 1'b0);
        gen_cell(0);
        phy_poll(DEV, 1'b1, "R4");
        d0 = ndone;
        phy_burst(53, 0, 1'b1);
        settle();
        check_eq("R6", "byte data mismatches", mismatches(1'b0), 0);
        check_eq("R6", "byte cell done", ndone - d0, 1);
        check_eq("R8", "upper bits outside parity", last_cnt, 0);

        phy_cell(3, "R6");

        // R5: other address not selected
        gen_cell(0);
        w0 = nwr;
        phy_poll(DEV ^ 5'd3, 1'b0, "R4");
        phy_burst(53, 0, 1'b0);
        settle();
        check_eq("R5", "writes when not selected", nwr - w0, 0);

        // R4: no room, no clav
        buf_room = 1'b0;
        phy_poll(DEV, 1'b0, "R4");
        buf_room = 1'b1;

        // R10: orphan transfers outside a cell
        gen_cell(0);
        w0 = nwr;
        phy_poll(DEV, 1'b1, "R4");
        phy_burst(6, 5, 1'b0);
        settle();
        check_eq("R10", "writes of orphan transfers", nwr - w0, 0);

        // R9: runt cell then full cell
        gen_cell(0);
        r0 = nrunt; d0 = ndone;
        phy_poll(DEV, 1'b1, "R4");
        phy_burst(10, 0, 1'b0);
        gen_cell(1);
        phy_poll(DEV, 1'b0, "R4");
        phy_burst(53, 0, 1'b0);
        settle();
        check_eq("R9", "runt flags", nrunt - r0, 1);
        check_eq("R9", "cells done after runt", ndone - d0, 1);
        check_eq("R9", "restart data mismatches", mismatches(1'b0), 0);
        check_eq("R8", "count after runt", last_cnt, 1);

        // PHY-side role, 16-bit mode, random error counts
        apply_reset(1'b1, 1'b1);
        for (int c = 0; c < 4; c++) phy_cell(int'($urandom % 4), "R7");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchecks++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

endmodule